// File: doc/BRIEF.md
# Video Display Image Window Generator

This block sits on the pixel output path of a video display and confines the displayed picture to a programmable rectangle at the top-left corner of the active area. Free-running frame counters walk every pixel position of an interlaced frame made of two equal fields. Per-line and per-field image counters track how much of the picture has been sent. While the current pixel lies inside the window, the input pixel stream is passed through and one input pixel is consumed. Once the programmed width has been reached on a line, a programmable default value fills the rest of that active line. Once the programmed height has been reached in a field, the default value fills the rest of that field. Blanking positions always carry a fixed blanking value.

A field flag output is driven only by the frame counters and two programmable start coordinates. It switches at a chosen pixel of a chosen line, so the downstream encoder can place it with pixel accuracy. A small 32-bit register file holds the window size, the two field-start coordinate pairs and the default value. Size and mode changes are held in shadow registers until the next field starts.

The classifier is a four-state machine. ST_VBLANK covers every pixel of a vertical blanking line. ST_HBLANK covers the horizontal blanking pixels of an active line. ST_IMAGE covers pixels inside the window. ST_FILL covers active pixels outside the window. Its named transitions are:
- VBLANK→HBLANK: first active line of a field begins.
- HBLANK→IMAGE: the line opens and the window is not exhausted.
- HBLANK→FILL: the line opens with the width or height already used up.
- IMAGE→FILL: the width is reached mid-line.
- IMAGE/FILL→HBLANK: line wrap onto another active line.
- IMAGE/FILL→VBLANK: line wrap into a blanking line.
- VBLANK→VBLANK: stays for the whole blanking line.

Top module: `vid_window_gen`

## Requirements
- R1: The pixel counter `frm_x` counts 0..H_TOTAL-1 and the line counter `frm_y` counts 0..2*FIELD_LINES-1, both starting at 0 after reset. Field 1 holds lines below FIELD_LINES and field 2 holds the rest. The first V_BLANK lines of each field and the first H_BLANK pixels of each line are blanking. At those positions `pix_active`=0, `img_rd`=0 and `pix_out`=BLANK_VAL.
- R2: At active column x=`frm_x`-H_BLANK of active line y (line within field minus V_BLANK), the pixel is an image pixel when x < width and y < height. For an image pixel, `pix_out`=`pix_in`, `img_rd`=1 and `pix_active`=1.
- R3: After the width count of image pixels on a line, the remaining active pixels of that line carry the default value with `img_rd`=0.
- R4: After the height count of image lines in a field, all remaining active pixels of that field carry the default value.
- R5: A width or a height of 0 produces no image pixel, so every active pixel of the field carries the default value.
- R6: With `raw_mode`=0 the least significant bit of the width is treated as 0. With `raw_mode`=1 the width is used exactly.
- R7: Register address 0 holds the height in bits 27:16 and the width in bits 11:0, both reset to 0. Bits 31:28 and 15:12 read 0 and ignore writes. All registers read 0 after reset.
- R8: Address 1 holds the field-1 start as Y in 27:16 and X in 11:0. `fld_out` is 0 in the cycle where (`frm_y`,`frm_x`) equals that pair, and it keeps that value until the field-2 pair is reached.
- R9: Address 2 holds the field-2 start in the same layout. `fld_out` is 1 in the cycle where the counters equal that pair. When both pairs are equal, the field-1 value wins.
- R10: Width, height and `raw_mode` are sampled only when the counters move to pixel 0 of line 0 or of line FIELD_LINES. A write in mid-field leaves the current field's clipping unchanged.
- R11: Address 3 holds the default value in its low bits. The register is live, so a write changes the fill value from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_mode | input | 1 | 1 = width used exactly, 0 = width forced even |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| pix_in | input | PIX_W | Image pixel stream |
| pix_out | output | PIX_W | Output pixel |
| img_rd | output | 1 | Current pixel consumes pix_in |
| pix_active | output | 1 | Current pixel is in the active area |
| fld_out | output | 1 | Field flag, 1 = field 2 |
| frm_x | output | 12 | Frame pixel counter |
| frm_y | output | 12 | Frame line counter |

## Verification
Every cycle, the assertions check that the frame counter wraps at line end, that the image counters never pass the shadowed width and height, and that a zero size never yields an image pixel. They also check that an even-width window in the default mode stops on an even count, that the shadow sizes only move at a field start, and that the field flag takes the right value after a coordinate match. Only the bench's scenarios can show that the window has the right position and shape across whole frames under several size, mode and coordinate settings. The same holds for the delay of a mid-field size write until the next field, for the live fill value, and for the register read-back with masked reserved bits.

// File: rtl/vw_pkg.sv
package vw_pkg;
    localparam int FLD_W = 12;

    localparam logic [1:0] ADDR_SIZE  = 2'd0;
    localparam logic [1:0] ADDR_F1    = 2'd1;
    localparam logic [1:0] ADDR_F2    = 2'd2;
    localparam logic [1:0] ADDR_DFLT  = 2'd3;

    typedef enum logic [1:0] {
        ST_VBLANK = 2'd0,
        ST_HBLANK = 2'd1,
        ST_IMAGE  = 2'd2,
        ST_FILL   = 2'd3
    } vw_state_e;
endpackage

// File: rtl/vw_regs.sv
module vw_regs
    import vw_pkg::*;
#(
    parameter int PIX_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [FLD_W-1:0]  size_w,
    output logic [FLD_W-1:0]  size_h,
    output logic [FLD_W-1:0]  f1_x,
    output logic [FLD_W-1:0]  f1_y,
    output logic [FLD_W-1:0]  f2_x,
    output logic [FLD_W-1:0]  f2_y,
    output logic [PIX_W-1:0]  dflt
);
    localparam int HI_LSB = 16;
    localparam int NUM_START = 2;

    logic [FLD_W-1:0] start_x [NUM_START];
    logic [FLD_W-1:0] start_y [NUM_START];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_w <= '0;
            size_h <= '0;
        end else if (reg_wr && reg_addr == ADDR_SIZE) begin
            size_w <= reg_wdata[FLD_W-1:0];
            size_h <= reg_wdata[HI_LSB +: FLD_W];
        end
    end

    // one coordinate register per field start
    for (genvar g = 0; g < NUM_START; g++) begin : g_start
        localparam logic [1:0] MY_ADDR = ADDR_F1 + 2'(g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                start_x[g] <= '0;
                start_y[g] <= '0;
            end else if (reg_wr && reg_addr == MY_ADDR) begin
                start_x[g] <= reg_wdata[FLD_W-1:0];
                start_y[g] <= reg_wdata[HI_LSB +: FLD_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dflt <= '0;
        end else if (reg_wr && reg_addr == ADDR_DFLT) begin
            dflt <= reg_wdata[PIX_W-1:0];
        end
    end

    assign f1_x = start_x[0];
    assign f1_y = start_y[0];
    assign f2_x = start_x[1];
    assign f2_y = start_y[1];

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_SIZE: begin
                reg_rdata[FLD_W-1:0]       = size_w;
                reg_rdata[HI_LSB +: FLD_W] = size_h;
            end
            ADDR_F1: begin
                reg_rdata[FLD_W-1:0]       = start_x[0];
                reg_rdata[HI_LSB +: FLD_W] = start_y[0];
            end
            ADDR_F2: begin
                reg_rdata[FLD_W-1:0]       = start_x[1];
                reg_rdata[HI_LSB +: FLD_W] = start_y[1];
            end
            ADDR_DFLT: begin
                reg_rdata[PIX_W-1:0]       = dflt;
            end
        endcase
    end

    // R7
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_SIZE) |-> (reg_rdata[31:28] == 4'd0 && reg_rdata[15:12] == 4'd0));

    // R7
    size_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_SIZE) |=> (size_w == $past(reg_wdata[FLD_W-1:0])
                                               && size_h == $past(reg_wdata[27:16])));
endmodule

// File: rtl/vw_frame_timing.sv
module vw_frame_timing
    import vw_pkg::*;
#(
    parameter int H_TOTAL     = 864,
    parameter int H_BLANK     = 144,
    parameter int FIELD_LINES = 312,
    parameter int V_BLANK     = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [FLD_W-1:0] fp,
    output logic [FLD_W-1:0] fl,
    output logic [FLD_W-1:0] nfp,
    output logic [FLD_W-1:0] nfl,
    output logic             n_field_start,
    output logic             n_line_wrap,
    output logic             n_hact,
    output logic             n_hact_start,
    output logic             n_vact
);
    localparam int FRAME_LINES = 2 * FIELD_LINES;
    localparam logic [FLD_W-1:0] X_LAST = FLD_W'(H_TOTAL - 1);
    localparam logic [FLD_W-1:0] Y_LAST = FLD_W'(FRAME_LINES - 1);
    localparam logic [FLD_W-1:0] X_ACT  = FLD_W'(H_BLANK);
    localparam logic [FLD_W-1:0] Y_F2   = FLD_W'(FIELD_LINES);
    localparam logic [FLD_W-1:0] Y_ACT  = FLD_W'(V_BLANK);

    logic             x_wrap;
    logic [FLD_W-1:0] line_in_fld;

    always_comb begin
        x_wrap = (fp == X_LAST);
        nfp    = x_wrap ? '0 : fp + 1'b1;
        if (x_wrap) nfl = (fl == Y_LAST) ? '0 : fl + 1'b1;
        else        nfl = fl;
        line_in_fld   = (nfl >= Y_F2) ? nfl - Y_F2 : nfl;
        n_line_wrap   = x_wrap;
        n_field_start = x_wrap && (nfl == '0 || nfl == Y_F2);
        n_hact        = (nfp >= X_ACT);
        n_hact_start  = (nfp == X_ACT);
        n_vact        = (line_in_fld >= Y_ACT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fp <= '0;
            fl <= '0;
        end else begin
            fp <= nfp;
            fl <= nfl;
        end
    end

    // R1
    x_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fp == X_LAST) |=> (fp == '0));

    // R1
    y_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl <= Y_LAST) && (fp <= X_LAST));
endmodule

// File: rtl/vw_window_fsm.sv
module vw_window_fsm
    import vw_pkg::*;
#(
    parameter int               PIX_W     = 12,
    parameter logic [PIX_W-1:0] BLANK_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw_mode,
    input  logic [FLD_W-1:0] prog_w,
    input  logic [FLD_W-1:0] prog_h,
    input  logic [PIX_W-1:0] dflt,
    input  logic [PIX_W-1:0] pix_in,
    input  logic             n_field_start,
    input  logic             n_line_wrap,
    input  logic             n_hact,
    input  logic             n_hact_start,
    input  logic             n_vact,
    output logic [PIX_W-1:0] pix_out,
    output logic             img_rd,
    output logic             pix_active
);
    vw_state_e        state_q, state_nx;
    logic [FLD_W-1:0] ipc_q, ipc_nx;
    logic [FLD_W-1:0] ilc_q, ilc_nx;
    logic [FLD_W-1:0] w_sh, h_sh, w_load, w_nx, h_nx;
    logic             raw_sh, raw_nx;
    logic             line_done;
    logic [FLD_W:0]   ipc_inc;

    // shadow values applied at a field boundary only
    always_comb begin
        w_load = raw_mode ? prog_w : {prog_w[FLD_W-1:1], 1'b0};
        w_nx   = n_field_start ? w_load   : w_sh;
        h_nx   = n_field_start ? prog_h   : h_sh;
        raw_nx = n_field_start ? raw_mode : raw_sh;
    end

    // next-state and counter logic
    always_comb begin
        ipc_inc   = {1'b0, ipc_q} + 1'b1;
        line_done = 1'b0;
        unique case (state_q)
            ST_IMAGE:  line_done = (ipc_inc >= {1'b0, w_sh}) || n_line_wrap;
            ST_VBLANK,
            ST_HBLANK,
            ST_FILL:   line_done = 1'b0;
        endcase

        if (n_field_start || n_hact_start) ipc_nx = '0;
        else if (state_q == ST_IMAGE)      ipc_nx = ipc_q + 1'b1;
        else                               ipc_nx = ipc_q;

        if (n_field_start)  ilc_nx = '0;
        else if (line_done) ilc_nx = ilc_q + 1'b1;
        else                ilc_nx = ilc_q;

        if (!n_vact)                                state_nx = ST_VBLANK;
        else if (!n_hact)                           state_nx = ST_HBLANK;
        else if (ipc_nx < w_nx && ilc_nx < h_nx)    state_nx = ST_IMAGE;
        else                                        state_nx = ST_FILL;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_VBLANK;
            ipc_q   <= '0;
            ilc_q   <= '0;
            w_sh    <= '0;
            h_sh    <= '0;
            raw_sh  <= 1'b0;
        end else begin
            state_q <= state_nx;
            ipc_q   <= ipc_nx;
            ilc_q   <= ilc_nx;
            w_sh    <= w_nx;
            h_sh    <= h_nx;
            raw_sh  <= raw_nx;
        end
    end

    // outputs
    always_comb begin
        pix_out    = BLANK_VAL;
        img_rd     = 1'b0;
        pix_active = 1'b0;
        unique case (state_q)
            ST_VBLANK, ST_HBLANK: begin
                pix_out    = BLANK_VAL;
            end
            ST_IMAGE: begin
                pix_out    = pix_in;
                img_rd     = 1'b1;
                pix_active = 1'b1;
            end
            ST_FILL: begin
                pix_out    = dflt;
                pix_active = 1'b1;
            end
        endcase
    end

    // R3
    ipc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ipc_q <= w_sh);

    // R4
    ilc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ilc_q <= h_sh);

    // R5
    zero_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w_sh == '0 || h_sh == '0) |-> (state_q != ST_IMAGE));

    // R6
    even_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && $past(state_q) == ST_IMAGE && !raw_sh) |-> !ipc_q[0]);

    // R10
    size_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !n_field_start |=> ($stable(w_sh) && $stable(h_sh) && $stable(raw_sh)));
endmodule

// File: rtl/vw_field_flag.sv
module vw_field_flag
    import vw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FLD_W-1:0] nfp,
    input  logic [FLD_W-1:0] nfl,
    input  logic [FLD_W-1:0] f1_x,
    input  logic [FLD_W-1:0] f1_y,
    input  logic [FLD_W-1:0] f2_x,
    input  logic [FLD_W-1:0] f2_y,
    output logic             fld
);
    logic hit1, hit2;

    always_comb begin
        hit1 = (nfp == f1_x) && (nfl == f1_y);
        hit2 = (nfp == f2_x) && (nfl == f2_y);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    fld <= 1'b0;
        else if (hit1) fld <= 1'b0;
        else if (hit2) fld <= 1'b1;
    end

    // R8
    f1_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hit1) |-> !fld);

    // R9
    f2_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hit2) && !$past(hit1)) |-> fld);
endmodule

// File: rtl/vid_window_gen.sv
module vid_window_gen
    import vw_pkg::*;
#(
    parameter int               PIX_W       = 12,
    parameter int               H_TOTAL     = 864,
    parameter int               H_BLANK     = 144,
    parameter int               FIELD_LINES = 312,
    parameter int               V_BLANK     = 24,
    parameter logic [PIX_W-1:0] BLANK_VAL   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw_mode,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [PIX_W-1:0] pix_in,
    output logic [PIX_W-1:0] pix_out,
    output logic             img_rd,
    output logic             pix_active,
    output logic             fld_out,
    output logic [11:0]      frm_x,
    output logic [11:0]      frm_y
);
    logic [FLD_W-1:0] size_w, size_h, f1_x, f1_y, f2_x, f2_y;
    logic [PIX_W-1:0] dflt;
    logic [FLD_W-1:0] fp, fl, nfp, nfl;
    logic             n_field_start, n_line_wrap, n_hact, n_hact_start, n_vact;

    vw_regs #(.PIX_W(PIX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .size_w    (size_w),
        .size_h    (size_h),
        .f1_x      (f1_x),
        .f1_y      (f1_y),
        .f2_x      (f2_x),
        .f2_y      (f2_y),
        .dflt      (dflt)
    );

    vw_frame_timing #(
        .H_TOTAL     (H_TOTAL),
        .H_BLANK     (H_BLANK),
        .FIELD_LINES (FIELD_LINES),
        .V_BLANK     (V_BLANK)
    ) u_timing (
        .clk           (clk),
        .rst_n         (rst_n),
        .fp            (fp),
        .fl            (fl),
        .nfp           (nfp),
        .nfl           (nfl),
        .n_field_start (n_field_start),
        .n_line_wrap   (n_line_wrap),
        .n_hact        (n_hact),
        .n_hact_start  (n_hact_start),
        .n_vact        (n_vact)
    );

    vw_window_fsm #(.PIX_W(PIX_W), .BLANK_VAL(BLANK_VAL)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .raw_mode      (raw_mode),
        .prog_w        (size_w),
        .prog_h        (size_h),
        .dflt          (dflt),
        .pix_in        (pix_in),
        .n_field_start (n_field_start),
        .n_line_wrap   (n_line_wrap),
        .n_hact        (n_hact),
        .n_hact_start  (n_hact_start),
        .n_vact        (n_vact),
        .pix_out       (pix_out),
        .img_rd        (img_rd),
        .pix_active    (pix_active)
    );

    vw_field_flag u_fld (
        .clk   (clk),
        .rst_n (rst_n),
        .nfp   (nfp),
        .nfl   (nfl),
        .f1_x  (f1_x),
        .f1_y  (f1_y),
        .f2_x  (f2_x),
        .f2_y  (f2_y),
        .fld   (fld_out)
    );

    assign frm_x = fp;
    assign frm_y = fl;

    // R1
    blank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_active |-> (!img_rd && pix_out == BLANK_VAL));
endmodule

// File: tb/tb_vid_window_gen.sv
module tb_vid_window_gen;
    localparam int HT = 16;
    localparam int HB = 4;
    localparam int FL = 8;
    localparam int VB = 2;
    localparam int FRAME = HT * 2 * FL;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        raw_mode = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic [11:0] pix_in = 12'd0;
    logic [11:0] pix_out;
    logic        img_rd, pix_active, fld_out;
    logic [11:0] frm_x, frm_y;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    vid_window_gen #(
        .PIX_W(12), .H_TOTAL(HT), .H_BLANK(HB), .FIELD_LINES(FL), .V_BLANK(VB),
        .BLANK_VAL(12'h000)
    ) dut (
        .clk(clk), .rst_n(rst_n), .raw_mode(raw_mode), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pix_in(pix_in), .pix_out(pix_out), .img_rd(img_rd),
        .pix_active(pix_active), .fld_out(fld_out), .frm_x(frm_x), .frm_y(frm_y)
    );

    typedef struct {
        int          x;
        int          y;
        logic        act;
        logic        img;
        logic [11:0] pix;
        logic        fld;
        string       tg;
        string       ftg;
    } exp_t;

    exp_t q[$];

    // bench model of the programmed registers
    int pw = 0, ph = 0, f1x = 0, f1y = 0, f2x = 0, f2y = 0;
    logic [11:0] dm = 12'd0;
    // model position and field state
    int bx = 0, by = 0, sw = 0, sh = 0;
    logic sraw = 1'b0, fld_m = 1'b0;

    function automatic logic [11:0] pin_f(input int x, input int y);
        return 12'((y << 6) ^ x ^ 12'h5A3);
    endfunction

    task automatic chk(input bit ok, input string tg, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tg, act, exp);
        end
    endtask

    // driver side: predict each cycle and push the expected item
    always @(posedge clk) begin
        if (!rst_n) begin
            bx = 0; by = 0; sw = 0; sh = 0; sraw = 1'b0; fld_m = 1'b0;
        end else begin
            bx = bx + 1;
            if (bx == HT) begin
                bx = 0;
                by = (by == 2 * FL - 1) ? 0 : by + 1;
            end
            if (bx == 0 && (by == 0 || by == FL)) begin   // R10 field start sampling
                sw = raw_mode ? pw : (pw & ~1);
                sh = ph;
                sraw = raw_mode;
            end
            if (by == f1y && bx == f1x)      fld_m = 1'b0;
            else if (by == f2y && bx == f2x) fld_m = 1'b1;
            #3;
            pix_in = pin_f(bx, by);
            begin
                exp_t it;
                int ly, ax, ay, pwe;
                ly = (by >= FL) ? by - FL : by;
                ax = bx - HB;
                ay = ly - VB;
                pwe = raw_mode ? pw : (pw & ~1);
                it.x = bx; it.y = by;
                it.act = (ly >= VB) && (bx >= HB);
                it.img = it.act && (ax < sw) && (ay < sh);
                it.pix = it.img ? pin_f(bx, by) : (it.act ? dm : 12'h000);
                it.fld = fld_m;
                if (!it.act)                          it.tg = "R1";
                else if (sw == 0 || sh == 0)          it.tg = "R5";
                else if (sw != pwe || sh != ph)       it.tg = "R10";
                else if (!sraw && pw[0] && ax == sw)  it.tg = "R6";
                else if (ay >= sh)                    it.tg = "R4";
                else if (ax >= sw)                    it.tg = "R3";
                else                                  it.tg = "R2";
                it.ftg = fld_m ? "R9" : "R8";
                q.push_back(it);
            end
        end
    end

    // monitor side: pop and compare away from the clock edge
    always @(negedge clk) begin
        if (q.size() != 0) begin
            exp_t it;
            it = q.pop_front();
            chk(frm_x == 12'(it.x) && frm_y == 12'(it.y), "R1",
                {8'd0, frm_y, frm_x}, {8'd0, 12'(it.y), 12'(it.x)});
            chk(pix_active == it.act, it.tg, 32'(pix_active), 32'(it.act));
            chk(img_rd == it.img, it.tg, 32'(img_rd), 32'(it.img));
            chk(pix_out == it.pix, (it.act && !it.img) ? "R11" : it.tg,
                32'(pix_out), 32'(it.pix));
            chk(fld_out == it.fld, it.ftg, 32'(fld_out), 32'(it.fld));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #2;
        unique case (a)
            2'd0: begin pw = int'(d[11:0]); ph = int'(d[27:16]); end
            2'd1: begin f1x = int'(d[11:0]); f1y = int'(d[27:16]); end
            2'd2: begin f2x = int'(d[11:0]); f2y = int'(d[27:16]); end
            2'd3: dm = d[11:0];
        endcase
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tg);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, tg, reg_rdata, exp);
    endtask

    task automatic run_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // reset state, R1 and R7
        repeat (3) @(negedge clk);
        chk(frm_x == 12'd0 && frm_y == 12'd0, "R1", {8'd0, frm_y, frm_x}, 32'd0);
        chk(pix_active == 1'b0 && img_rd == 1'b0 && fld_out == 1'b0, "R1",
            {29'd0, pix_active, img_rd, fld_out}, 32'd0);
        for (int a = 0; a < 4; a++) begin
            reg_addr = 2'(a);
            #0.5;
            chk(reg_rdata == 32'd0, "R7", reg_rdata, 32'd0);
        end
        rst_n = 1'b1;

        // R11 default value, R5 zero size fills everything
        wr(2'd3, 32'h0000_03C5);
        rd_chk(2'd3, 32'h0000_03C5, "R11");
        run_cycles(FRAME);

        // R10 mid-field write, R6 odd width forced even
        run_cycles(40);
        wr(2'd0, {4'hF, 12'd3, 4'hF, 12'd5});
        rd_chk(2'd0, {4'h0, 12'd3, 4'h0, 12'd5}, "R7");
        run_cycles(FRAME);

        // R6 raw mode keeps the odd width, R11 live default change
        raw_mode = 1'b1;
        run_cycles(FRAME / 2 + 10);
        wr(2'd3, 32'h0000_0A0F);
        run_cycles(FRAME);

        // R8 and R9 field flag coordinates
        wr(2'd1, {4'd0, 12'd1, 4'd0, 12'd3});
        wr(2'd2, {4'd0, 12'd9, 4'd0, 12'd7});
        rd_chk(2'd1, {4'd0, 12'd1, 4'd0, 12'd3}, "R8");
        rd_chk(2'd2, {4'd0, 12'd9, 4'd0, 12'd7}, "R9");
        run_cycles(2 * FRAME);

        // R7 reserved bits, oversized window clipped by the active area (R2)
        wr(2'd0, 32'hFFFF_FFFF);
        rd_chk(2'd0, 32'h0FFF_0FFF, "R7");
        // R9 equal coordinates: field-1 value wins
        wr(2'd2, {4'd0, 12'd1, 4'd0, 12'd3});
        run_cycles(FRAME);

        // exact fit, even mode, R3/R4 boundaries at the active edges
        raw_mode = 1'b0;
        wr(2'd0, {4'd0, 12'd6, 4'd0, 12'd12});
        wr(2'd2, {4'd0, 12'd12, 4'd0, 12'd0});
        run_cycles(FRAME + 20);

        // R4 height below the active lines, R3 narrow width
        wr(2'd0, {4'd0, 12'd2, 4'd0, 12'd2});
        run_cycles(FRAME + 20);

        wait (q.size() == 0);
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule